// File: doc/BRIEF.md
# Set-Associative Cache Policy Engine

This block models only the tags of a small two-way set-associative cache. It holds four blocks arranged as two sets of two ways. Each incoming block address is looked up in one cycle and reported as a hit or a miss. On a miss the block fills a free way of its set if one exists. Otherwise a victim way is chosen by the replacement policy selected on that request. The choices are least recently used, most recently used and pseudo-random.

A per-request bypass flag lets a miss skip allocation altogether. Running hit and miss counters make it easy to compare how policy and bypass choices change the hit count over a sequence of addresses. Data storage, write handling and refill timing are not part of the block.

The result of a request is registered. It appears on the outputs in the cycle after the request is presented and lasts for one cycle.

Top module: `assoc_policy_cache`

## Requirements
- R1: After reset is asserted (rst_ni low), `hit_o`, `miss_o` and `evict_valid_o` are 0, both counters are 0, and every way is empty, so the first access to any address misses.
- R2: The set index is the low `$clog2(NUM_SETS)` bits of the block address, which is bit 0 with the defaults: even addresses use set 0 and odd addresses use set 1. The remaining bits form the tag. `evict_addr_o` rebuilds the full address of the evicted block, and traffic to one set never changes the contents of the other set.
- R3: For a request accepted at a clock edge, exactly one of `hit_o` or `miss_o` is 1 in the following cycle. A cycle with no request is followed by a cycle with both outputs at 0.
- R4: On an allocating miss, way 0 is filled if it is empty, and way 1 is filled next. No eviction is reported while the set still has an empty way.
- R5: Policy code 0 selects least recently used, and code 3 behaves the same way. The victim is the way of the full set that was not referenced most recently. Both hits and fills update the recency of the set.
- R6: Policy code 1 selects most recently used. The victim is the way of the full set that was referenced most recently.
- R7: Policy code 2 selects random replacement. The victim is bit 0 of an 8-bit LFSR: 0 evicts way 0 and 1 evicts way 1. The LFSR is seeded with 8'hA5. Each step shifts it left and inserts the XOR of bits 7, 5, 4 and 3. It steps only when a random-policy eviction occurs.
- R8: A miss with `bypass_i` set installs nothing and evicts nothing. A hit with `bypass_i` set is still a hit and still updates recency.
- R9: `hit_count_o` and `miss_count_o` each increase by exactly one in the cycle in which `hit_o` or `miss_o`, respectively, is 1. At all other times they hold their value.
- R10: From an empty cache under least recently used, the sequence 0,1,2,3,4 misses five times and the fifth access evicts block 0. The sequence 0,2,4,8,10,12,14,16,0 gives 0 hits under least recently used and 1 hit under most recently used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request strobe |
| req_addr_i | input | ADDR_W | Block address of the request |
| policy_i | input | 2 | Replacement policy: 0 LRU, 1 MRU, 2 random, 3 LRU |
| bypass_i | input | 1 | Do not allocate on a miss |
| hit_o | output | 1 | Previous request hit |
| miss_o | output | 1 | Previous request missed |
| evict_valid_o | output | 1 | Previous request evicted a block |
| evict_addr_o | output | ADDR_W | Block address of the evicted block |
| hit_count_o | output | CNT_W | Running hit count |
| miss_count_o | output | CNT_W | Running miss count |

## Verification
A request can hit on a resident block while also carrying the bypass flag. Two functions then meet in one cycle: allocation is suppressed, but the recency update from the hit must still happen. The bench provokes this by filling a set, re-referencing the older way with bypass set, and then forcing a least-recently-used miss. The evicted address shows whether the bypassed hit moved the recency bit. In the same way, random evictions are interleaved with LRU evictions. The next random victim shows whether the LFSR stepped only on the random evictions.

// File: rtl/apc_pkg.sv
package apc_pkg;
  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_MRU  = 2'd1,
    POL_RAND = 2'd2,
    POL_LRU2 = 2'd3
  } policy_e;
endpackage

// File: rtl/cache_lfsr.sv
module cache_lfsr #(
  parameter int unsigned      W    = 8,
  parameter logic [W-1:0]     SEED = 8'hA5,
  parameter logic [W-1:0]     TAPS = 8'hB8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic bit_o
);
  logic [W-1:0] q;
  logic         fb;

  assign fb    = ^(q & TAPS);
  assign bit_o = q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (step_i) q <= {q[W-2:0], fb};
  end
endmodule

// File: rtl/cache_set.sv
module cache_set
  import apc_pkg::*;
#(
  parameter int unsigned TAG_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [1:0]       policy_i,
  input  logic             bypass_i,
  input  logic             rnd_bit_i,
  output logic             hit_o,
  output logic             evict_o,
  output logic [TAG_W-1:0] evict_tag_o,
  output logic             rnd_used_o
);
  logic [1:0]       vld_q;
  logic [TAG_W-1:0] tag_q [2];
  logic             mru_q;   // way referenced most recently

  logic [1:0] way_hit;
  logic       hit_way, victim, fill_way, full, alloc;

  always_comb begin
    for (int w = 0; w < 2; w++) way_hit[w] = vld_q[w] && (tag_q[w] == tag_i);
  end

  assign hit_o   = |way_hit;
  assign hit_way = way_hit[1];
  assign full    = &vld_q;

  always_comb begin
    unique case (policy_e'(policy_i))
      POL_MRU:  victim = mru_q;
      POL_RAND: victim = rnd_bit_i;
      default:  victim = ~mru_q;
    endcase
  end

  assign fill_way    = !vld_q[0] ? 1'b0 : (!vld_q[1] ? 1'b1 : victim);
  assign alloc       = sel_i && !hit_o && !bypass_i;
  assign evict_o     = alloc && full;
  assign evict_tag_o = tag_q[victim];
  assign rnd_used_o  = evict_o && (policy_e'(policy_i) == POL_RAND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      mru_q <= 1'b0;
      for (int w = 0; w < 2; w++) tag_q[w] <= '0;
    end else if (sel_i) begin
      if (hit_o) begin
        mru_q <= hit_way;
      end else if (alloc) begin
        vld_q[fill_way] <= 1'b1;
        tag_q[fill_way] <= tag_i;
        mru_q           <= fill_way;
      end
    end
  end
endmodule

// File: rtl/assoc_policy_cache.sv
module assoc_policy_cache #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_SETS = 2,
  parameter int unsigned CNT_W    = 16,
  parameter logic [7:0]  LFSR_SEED = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        policy_i,
  input  logic              bypass_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              evict_valid_o,
  output logic [ADDR_W-1:0] evict_addr_o,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o
);
  localparam int unsigned IDX_W = $clog2(NUM_SETS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             rnd_bit, rnd_step;

  logic [NUM_SETS-1:0] set_hit, set_ev, set_rnd;
  logic [TAG_W-1:0]    set_ev_tag [NUM_SETS];

  assign idx = req_addr_i[IDX_W-1:0];
  assign tag = req_addr_i[ADDR_W-1:IDX_W];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    cache_set #(.TAG_W(TAG_W)) u_set (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (req_valid_i && (idx == IDX_W'(s))),
      .tag_i       (tag),
      .policy_i    (policy_i),
      .bypass_i    (bypass_i),
      .rnd_bit_i   (rnd_bit),
      .hit_o       (set_hit[s]),
      .evict_o     (set_ev[s]),
      .evict_tag_o (set_ev_tag[s]),
      .rnd_used_o  (set_rnd[s])
    );
  end

  assign rnd_step = |set_rnd;

  cache_lfsr #(.W(8), .SEED(LFSR_SEED), .TAPS(8'hB8)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (rnd_step),
    .bit_o  (rnd_bit)
  );

  logic look_hit;
  assign look_hit = set_hit[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o         <= 1'b0;
      miss_o        <= 1'b0;
      evict_valid_o <= 1'b0;
      evict_addr_o  <= '0;
      hit_count_o   <= '0;
      miss_count_o  <= '0;
    end else begin
      hit_o         <= req_valid_i && look_hit;
      miss_o        <= req_valid_i && !look_hit;
      evict_valid_o <= set_ev[idx];
      if (set_ev[idx]) evict_addr_o <= {set_ev_tag[idx], idx};
      if (req_valid_i && look_hit)  hit_count_o  <= hit_count_o + 1'b1;
      if (req_valid_i && !look_hit) miss_count_o <= miss_count_o + 1'b1;
    end
  end
endmodule

// File: rtl/assoc_policy_cache_chk.sv
module assoc_policy_cache_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             bypass_i,
  input logic             hit_o,
  input logic             miss_o,
  input logic             evict_valid_o,
  input logic [CNT_W-1:0] hit_count_o,
  input logic [CNT_W-1:0] miss_count_o
);
  assert_hit_miss_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  assert_resp_after_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (hit_o || miss_o));

  assert_quiet_when_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!hit_o && !miss_o));

  assert_evict_only_on_miss_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> miss_o);

  assert_bypass_no_evict_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && bypass_i) |=> !evict_valid_o);

  assert_hit_count_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (hit_count_o == CNT_W'($past(hit_count_o) + 1'b1)));

  assert_hit_count_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> $stable(hit_count_o));

  assert_miss_count_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (miss_count_o == CNT_W'($past(miss_count_o) + 1'b1)));

  assert_miss_count_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_o |-> $stable(miss_count_o));
endmodule

bind assoc_policy_cache assoc_policy_cache_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/assoc_policy_cache_test.sv
`timescale 1ns/1ps
module assoc_policy_cache_test;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [1:0]        policy_i = 2'd0;
  logic              bypass_i = 1'b0;
  logic              hit_o, miss_o, evict_valid_o;
  logic [ADDR_W-1:0] evict_addr_o;
  logic [CNT_W-1:0]  hit_count_o, miss_count_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk_i = ~clk_i;

  assoc_policy_cache uut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid_i = 1'b0;
    bypass_i    = 1'b0;
    rst_ni      = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // one request; result sampled one negedge later
  task automatic access(input int a, input int pol, input bit byp, input bit exp_hit,
                        input bit exp_ev, input int exp_ea, input string req);
    req_valid_i = 1'b1;
    req_addr_i  = ADDR_W'(a);
    policy_i    = 2'(pol);
    bypass_i    = byp;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    bypass_i    = 1'b0;
    check(req, $sformatf("hit addr %0d", a), int'(hit_o), int'(exp_hit));
    check(req, $sformatf("miss addr %0d", a), int'(miss_o), int'(!exp_hit));
    check(req, $sformatf("evict_valid addr %0d", a), int'(evict_valid_o), int'(exp_ev));
    if (exp_ev) check(req, $sformatf("evict_addr addr %0d", a), int'(evict_addr_o), exp_ea);
  endtask

  task automatic t_reset_r1();
    do_reset();
    check("R1", "hit_o", int'(hit_o), 0);
    check("R1", "miss_o", int'(miss_o), 0);
    check("R1", "evict_valid_o", int'(evict_valid_o), 0);
    check("R1", "hit_count", int'(hit_count_o), 0);
    check("R1", "miss_count", int'(miss_count_o), 0);
    access(0, 0, 0, 0, 0, 0, "R1");
    access(0, 0, 0, 1, 0, 0, "R1");
    do_reset();
    access(0, 0, 0, 0, 0, 0, "R1");   // reset empties the cache again
  endtask

  task automatic t_seq5_r10();
    do_reset();
    access(0, 0, 0, 0, 0, 0, "R10");
    access(1, 0, 0, 0, 0, 0, "R10");
    access(2, 0, 0, 0, 0, 0, "R4");
    access(3, 0, 0, 0, 0, 0, "R4");
    access(4, 0, 0, 0, 1, 0, "R10");
    check("R10", "miss_count", int'(miss_count_o), 5);
    // odd set untouched by set-0 eviction (R2)
    access(1, 0, 0, 1, 0, 0, "R2");
    access(3, 0, 0, 1, 0, 0, "R2");
    access(2, 0, 0, 1, 0, 0, "R2");
  endtask

  task automatic t_seq9(input int pol, input int exp_hits, input string req);
    int seq[9] = '{0, 2, 4, 8, 10, 12, 14, 16, 0};
    do_reset();
    for (int i = 0; i < 9; i++) begin
      req_valid_i = 1'b1;
      req_addr_i  = ADDR_W'(seq[i]);
      policy_i    = 2'(pol);
      @(negedge clk_i);
      req_valid_i = 1'b0;
    end
    check(req, "seq9 hit_count", int'(hit_count_o), exp_hits);
    check("R9", "seq9 miss_count", int'(miss_count_o), 9 - exp_hits);
  endtask

  task automatic t_lru_hit_update_r5();
    do_reset();
    access(0, 0, 0, 0, 0, 0, "R5");
    access(2, 0, 0, 0, 0, 0, "R5");
    access(0, 0, 0, 1, 0, 0, "R5");
    access(4, 0, 0, 0, 1, 2, "R5");   // 2 is least recent
    access(6, 3, 0, 0, 1, 0, "R5");   // code 3 acts as LRU: 0 older than 4
  endtask

  task automatic t_mru_r6();
    do_reset();
    access(5, 1, 0, 0, 0, 0, "R6");
    access(7, 1, 0, 0, 0, 0, "R6");
    access(5, 1, 0, 1, 0, 0, "R6");
    access(9, 1, 0, 0, 1, 5, "R6");   // 5 most recent
    access(7, 1, 0, 1, 0, 0, "R6");
  endtask

  task automatic t_random_r7();
    logic [7:0] lfsr = 8'hA5;
    int ways[2];
    bit mru;
    int addrs[6] = '{4, 8, 10, 12, 14, 18};
    int pols[6]  = '{2, 2, 0, 2, 2, 1};
    do_reset();
    access(0, 2, 0, 0, 0, 0, "R7");
    access(2, 2, 0, 0, 0, 0, "R7");
    ways[0] = 0; ways[1] = 2; mru = 1'b1;
    for (int i = 0; i < 6; i++) begin
      bit v;
      if (pols[i] == 2)      v = lfsr[0];
      else if (pols[i] == 0) v = ~mru;
      else                   v = mru;
      access(addrs[i], pols[i], 0, 0, 1, ways[v], "R7");
      ways[v] = addrs[i];
      mru = v;
      if (pols[i] == 2) lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
  endtask

  task automatic t_bypass_r8();
    do_reset();
    access(1, 0, 1, 0, 0, 0, "R8");   // bypass into empty set
    access(1, 0, 0, 0, 0, 0, "R8");   // still absent
    access(0, 0, 0, 0, 0, 0, "R8");
    access(2, 0, 0, 0, 0, 0, "R8");
    access(4, 0, 1, 0, 0, 0, "R8");   // full set, bypass: no evict
    access(0, 0, 0, 1, 0, 0, "R8");
    access(2, 0, 0, 1, 0, 0, "R8");
    access(4, 0, 0, 0, 1, 0, "R8");   // recency: 2 newest, 0 evicted
    // bypassed hit still updates recency
    access(2, 0, 1, 1, 0, 0, "R8");
    access(6, 0, 0, 0, 1, 4, "R8");
  endtask

  task automatic t_idle_counters_r9();
    int h, m;
    do_reset();
    access(0, 0, 0, 0, 0, 0, "R9");
    access(0, 0, 0, 1, 0, 0, "R9");
    h = int'(hit_count_o); m = int'(miss_count_o);
    check("R9", "hit_count", h, 1);
    check("R9", "miss_count", m, 1);
    repeat (3) @(negedge clk_i);
    check("R3", "idle hit_o", int'(hit_o), 0);
    check("R3", "idle miss_o", int'(miss_o), 0);
    check("R9", "idle hit_count", int'(hit_count_o), h);
    check("R9", "idle miss_count", int'(miss_count_o), m);
  endtask

  initial begin
    t_reset_r1();
    t_seq5_r10();
    t_seq9(0, 0, "R10");
    t_seq9(1, 1, "R10");
    t_lru_hit_update_r5();
    t_mru_r6();
    t_random_r7();
    t_bypass_r8();
    t_idle_counters_r9();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk_i);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule